// File: doc/BRIEF.md
# Reset and NMI Trap Controller

This block sits next to a simple in-order CPU pipeline and takes care of the two most severe traps: a reset request and a non-maskable interrupt. Both traps send instruction fetch to one shared vector address. A sticky status flag records which of the two happened last, so the handler can tell them apart. On each trap the block saves a return address in an error-return register. When the trapping instruction sits in a branch delay slot, that address is moved back to the branch, and a delay-slot flag records the move.

The block also holds an exception-level bit. A trap sets it, which closes the gate for ordinary maskable interrupts. The bit is cleared either by an exception-return strobe, which also redirects fetch to the saved address, or by a software write that lets a handler accept nested interrupts. Every redirect appears as a one-cycle strobe on the clock after the event, with the target address beside it.

Top module: `rnmi_trap_ctrl`

## Requirements
- R1: On the clock edge that samples `rst_req_i` high, or that samples a rising edge of `nmi_req_i`, `redirect_o` goes high for one cycle after that edge and `vector_o` shows RESET_VEC (default 0xBFC00000) for both kinds of trap.
- R2: After a reset-request trap `status_nmi_o` is 0. After an NMI trap it is 1.
- R3: ERET strobes and EXL writes leave `status_nmi_o` unchanged.
- R4: Any trap sets `status_exl_o` to 1. While `rst_n` is low, and after it is released, the outputs show `status_exl_o`=1, `status_nmi_o`=0, `cause_bd_o`=0, `redirect_o`=0 and `vector_o`=RESET_VEC.
- R5: `int_en_o` is 1 exactly when `status_exl_o` is 0.
- R6: An ERET with no trap in the same cycle clears `status_exl_o` on the next edge, raises `redirect_o` for one cycle, and sets `vector_o` to the value `ret_pc_o` held beforehand.
- R7: On a trap, `ret_pc_o` becomes `pc_i` when `dslot_i` is 0, and `pc_i` minus 4 when `dslot_i` is 1. Its value before the first trap is undefined.
- R8: On a trap, `cause_bd_o` takes the value of `dslot_i`. At all other times it holds.
- R9: When a reset request and an NMI rising edge arrive together, the reset trap is taken (`status_nmi_o`=0), and that NMI edge is used up.
- R10: An NMI request held high for many cycles causes exactly one trap.
- R11: `exl_wr_i` loads `exl_wdata_i` into `status_exl_o` only when there is no trap and no ERET in the same cycle. Otherwise the write is lost.
- R12: A trap takes precedence over an ERET in the same cycle: `vector_o` shows RESET_VEC and `status_exl_o` stays 1.
- R13: `vector_o` holds its last target in every cycle with no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rst_req_i | input | 1 | Reset-trap request (level, sampled each edge) |
| nmi_req_i | input | 1 | Non-maskable interrupt request (rising edge triggers) |
| pc_i | input | XLEN | PC of the instruction in the stage that takes traps |
| dslot_i | input | 1 | That instruction is in a branch delay slot |
| eret_i | input | 1 | Exception-return strobe |
| exl_wr_i | input | 1 | Software write strobe for EXL |
| exl_wdata_i | input | 1 | Value written to EXL |
| redirect_o | output | 1 | One-cycle fetch redirect strobe |
| vector_o | output | XLEN | Redirect target address |
| ret_pc_o | output | XLEN | Saved error-return PC |
| status_nmi_o | output | 1 | Last trap was an NMI |
| status_exl_o | output | 1 | Exception level |
| cause_bd_o | output | 1 | Last trap came from a delay slot |
| int_en_o | output | 1 | Gate for ordinary maskable interrupts |

## Verification
The properties assume that every input is synchronous to `clk`, that `nmi_req_i` has already been synchronized upstream, and that `rst_n` is released away from a rising edge. The delay-slot property also assumes that `pc_i` is at least 4 whenever `dslot_i` is high, so the predecessor address does not wrap. The stimulus drives all inputs on the falling edge, only ever releases reset on a falling edge, and uses word-aligned PCs of 0x100 and above.

// File: rtl/rnt_pkg.sv
package rnt_pkg;
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_RESET = 2'd1,
    EV_NMI   = 2'd2,
    EV_ERET  = 2'd3
  } trap_ev_e;

  typedef struct packed {
    logic nmi;
    logic exl;
  } trap_stat_t;
endpackage

// File: rtl/rnt_nmi_edge.sv
module rnt_nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic rise_o
);
  logic req_q;
  logic req_d;

  always_comb begin
    req_d  = req_i;
    rise_o = req_i & ~req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  // one held request must not fire twice in a row
  assert_single_nmi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/rnt_event_sel.sv
module rnt_event_sel
  import rnt_pkg::*;
(
  input  logic     rst_req_i,
  input  logic     nmi_rise_i,
  input  logic     eret_i,
  output trap_ev_e ev_o
);
  // reset beats NMI, any trap beats return
  always_comb begin
    if (rst_req_i)       ev_o = EV_RESET;
    else if (nmi_rise_i) ev_o = EV_NMI;
    else if (eret_i)     ev_o = EV_ERET;
    else                 ev_o = EV_NONE;
  end
endmodule

// File: rtl/rnt_pc_sel.sv
module rnt_pc_sel #(
  parameter int XLEN        = 32,
  parameter int INSTR_BYTES = 4
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic            dslot_i,
  output logic [XLEN-1:0] save_pc_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

  always_comb begin
    if (dslot_i) save_pc_o = pc_i - STEP;
    else         save_pc_o = pc_i;
  end
endmodule

// File: rtl/rnt_state.sv
module rnt_state
  import rnt_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VEC = 32'hBFC0_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  trap_ev_e        ev_i,
  input  logic [XLEN-1:0] save_pc_i,
  input  logic            dslot_i,
  input  logic            exl_wr_i,
  input  logic            exl_wdata_i,
  output trap_stat_t      stat_o,
  output logic            bd_o,
  output logic [XLEN-1:0] epc_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] vector_o
);
  trap_stat_t      stat_q, stat_d;
  logic            bd_q, bd_d;
  logic [XLEN-1:0] epc_q, epc_d;
  logic            epc_en;
  logic            redir_q, redir_d;
  logic [XLEN-1:0] vec_q, vec_d;
  logic            trap;

  assign trap = (ev_i == EV_RESET) || (ev_i == EV_NMI);

  always_comb begin
    stat_d  = stat_q;
    bd_d    = bd_q;
    epc_d   = save_pc_i;
    epc_en  = 1'b0;
    redir_d = 1'b0;
    vec_d   = vec_q;
    case (ev_i)
      EV_RESET, EV_NMI: begin
        stat_d.nmi = (ev_i == EV_NMI);
        stat_d.exl = 1'b1;
        bd_d       = dslot_i;
        epc_en     = 1'b1;
        redir_d    = 1'b1;
        vec_d      = RESET_VEC;
      end
      EV_ERET: begin
        stat_d.exl = 1'b0;
        redir_d    = 1'b1;
        vec_d      = epc_q;
      end
      default: begin
        if (exl_wr_i) stat_d.exl = exl_wdata_i;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '{nmi: 1'b0, exl: 1'b1};
      bd_q    <= 1'b0;
      redir_q <= 1'b0;
      vec_q   <= RESET_VEC;
    end else begin
      stat_q  <= stat_d;
      bd_q    <= bd_d;
      redir_q <= redir_d;
      vec_q   <= vec_d;
    end
  end

  // error-return PC: no reset, contents undefined until the first trap
  always_ff @(posedge clk) begin
    if (epc_en) epc_q <= epc_d;
  end

  assign stat_o     = stat_q;
  assign bd_o       = bd_q;
  assign epc_o      = epc_q;
  assign redirect_o = redir_q;
  assign vector_o   = vec_q;

  assert_shared_vector_R1: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> (redirect_o && vector_o == RESET_VEC));
  assert_nmi_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i == EV_NMI) |=> stat_o.nmi);
  assert_nmi_flag_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i == EV_RESET) |=> !stat_o.nmi);
  assert_nmi_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !trap |=> $stable(stat_o.nmi));
  assert_exl_on_trap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> stat_o.exl);
  assert_eret_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i == EV_ERET) |=> (!stat_o.exl && redirect_o && vector_o == $past(epc_o)));
  assert_bd_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> (bd_o == $past(dslot_i)));
  assert_bd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !trap |=> $stable(bd_o));
  assert_exl_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i == EV_NONE && exl_wr_i) |=> (stat_o.exl == $past(exl_wdata_i)));
  assert_vector_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect_o |-> $stable(vector_o));
endmodule

// File: rtl/rnmi_trap_ctrl.sv
module rnmi_trap_ctrl
  import rnt_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter int              INSTR_BYTES = 4,
  parameter logic [XLEN-1:0] RESET_VEC   = 32'hBFC0_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rst_req_i,
  input  logic            nmi_req_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            dslot_i,
  input  logic            eret_i,
  input  logic            exl_wr_i,
  input  logic            exl_wdata_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] vector_o,
  output logic [XLEN-1:0] ret_pc_o,
  output logic            status_nmi_o,
  output logic            status_exl_o,
  output logic            cause_bd_o,
  output logic            int_en_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

  logic            nmi_rise;
  trap_ev_e        ev;
  logic [XLEN-1:0] save_pc;
  trap_stat_t      stat;

  rnt_nmi_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (nmi_req_i),
    .rise_o (nmi_rise)
  );

  rnt_event_sel u_sel (
    .rst_req_i  (rst_req_i),
    .nmi_rise_i (nmi_rise),
    .eret_i     (eret_i),
    .ev_o       (ev)
  );

  rnt_pc_sel #(.XLEN(XLEN), .INSTR_BYTES(INSTR_BYTES)) u_pc (
    .pc_i      (pc_i),
    .dslot_i   (dslot_i),
    .save_pc_o (save_pc)
  );

  rnt_state #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_i        (ev),
    .save_pc_i   (save_pc),
    .dslot_i     (dslot_i),
    .exl_wr_i    (exl_wr_i),
    .exl_wdata_i (exl_wdata_i),
    .stat_o      (stat),
    .bd_o        (cause_bd_o),
    .epc_o       (ret_pc_o),
    .redirect_o  (redirect_o),
    .vector_o    (vector_o)
  );

  assign status_nmi_o = stat.nmi;
  assign status_exl_o = stat.exl;
  assign int_en_o     = ~stat.exl;

  assert_epc_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_i || nmi_rise) |=>
      (ret_pc_o == ($past(dslot_i) ? $past(pc_i) - STEP : $past(pc_i))));
  assert_reset_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_i && nmi_rise) |=> !status_nmi_o);
  assert_trap_over_eret_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((rst_req_i || nmi_rise) && eret_i) |=> (status_exl_o && vector_o == RESET_VEC));
endmodule

// File: tb/sim_rnmi_trap_ctrl.sv
`timescale 1ns/1ps
module sim_rnmi_trap_ctrl;
  localparam logic [31:0] V = 32'hBFC0_0000;

  typedef struct packed {
    logic        rr;
    logic        nmi;
    logic [31:0] pc;
    logic        ds;
    logic        er;
    logic        wr;
    logic        wd;
    logic        e_redir;
    logic [31:0] e_vec;
    logic [31:0] e_epc;
    logic        e_nmi;
    logic        e_exl;
    logic        e_bd;
  } vec_t;

  localparam int NV = 13;
  // rr nmi pc ds er wr wd | redir vec epc nmi exl bd
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,32'h100,1'b0,1'b0,1'b0,1'b0, 1'b1,V,      32'h100,1'b0,1'b1,1'b0}, // R1 R2 reset trap
    '{1'b0,1'b0,32'h104,1'b0,1'b0,1'b0,1'b0, 1'b0,V,      32'h100,1'b0,1'b1,1'b0}, // R13 hold
    '{1'b0,1'b0,32'h108,1'b0,1'b1,1'b0,1'b0, 1'b1,32'h100,32'h100,1'b0,1'b0,1'b0}, // R6 eret
    '{1'b0,1'b1,32'h200,1'b1,1'b0,1'b0,1'b0, 1'b1,V,      32'h1FC,1'b1,1'b1,1'b1}, // R7 R8 nmi in slot
    '{1'b0,1'b1,32'h204,1'b0,1'b0,1'b0,1'b0, 1'b0,V,      32'h1FC,1'b1,1'b1,1'b1}, // R10 held
    '{1'b0,1'b0,32'h208,1'b0,1'b0,1'b1,1'b0, 1'b0,V,      32'h1FC,1'b1,1'b0,1'b1}, // R11 R3 write
    '{1'b0,1'b0,32'h300,1'b0,1'b1,1'b0,1'b0, 1'b1,32'h1FC,32'h1FC,1'b1,1'b0,1'b1}, // R3 R6 eret
    '{1'b1,1'b1,32'h400,1'b1,1'b0,1'b0,1'b0, 1'b1,V,      32'h3FC,1'b0,1'b1,1'b1}, // R9 collision
    '{1'b0,1'b1,32'h404,1'b0,1'b0,1'b0,1'b0, 1'b0,V,      32'h3FC,1'b0,1'b1,1'b1}, // R9 edge used
    '{1'b1,1'b0,32'h500,1'b0,1'b1,1'b0,1'b0, 1'b1,V,      32'h500,1'b0,1'b1,1'b0}, // R12
    '{1'b0,1'b0,32'h504,1'b0,1'b1,1'b1,1'b0, 1'b1,32'h500,32'h500,1'b0,1'b0,1'b0}, // R11 eret wins
    '{1'b0,1'b0,32'h508,1'b0,1'b0,1'b1,1'b1, 1'b0,32'h500,32'h500,1'b0,1'b1,1'b0}, // R11 R13
    '{1'b0,1'b1,32'h600,1'b0,1'b0,1'b1,1'b0, 1'b1,V,      32'h600,1'b1,1'b1,1'b0}  // R11 trap wins
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rst_req, nmi_req, dslot, eret, exl_wr, exl_wdata;
  logic [31:0] pc;
  logic        redirect, status_nmi, status_exl, cause_bd, int_en;
  logic [31:0] vector, ret_pc;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rnmi_trap_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .rst_req_i(rst_req), .nmi_req_i(nmi_req),
    .pc_i(pc), .dslot_i(dslot), .eret_i(eret), .exl_wr_i(exl_wr),
    .exl_wdata_i(exl_wdata), .redirect_o(redirect), .vector_o(vector),
    .ret_pc_o(ret_pc), .status_nmi_o(status_nmi), .status_exl_o(status_exl),
    .cause_bd_o(cause_bd), .int_en_o(int_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    rst_req = 0; nmi_req = 0; pc = 32'h0; dslot = 0;
    eret = 0; exl_wr = 0; exl_wdata = 0;
  endtask

  task automatic chk_reset_state(input string tag);
    chk({tag, " R4 redirect"}, 32'(redirect), 32'd0);
    chk({tag, " R4 exl"},      32'(status_exl), 32'd1);
    chk({tag, " R4 nmi"},      32'(status_nmi), 32'd0);
    chk({tag, " R4 bd"},       32'(cause_bd), 32'd0);
    chk({tag, " R4 vector"},   vector, V);
    chk({tag, " R5 int_en"},   32'(int_en), 32'd0);
  endtask

  initial begin
    int pulses;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_reset_state("in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_reset_state("after release");

    for (int i = 0; i < NV; i++) begin
      rst_req = TBL[i].rr; nmi_req = TBL[i].nmi; pc = TBL[i].pc;
      dslot = TBL[i].ds; eret = TBL[i].er; exl_wr = TBL[i].wr;
      exl_wdata = TBL[i].wd;
      @(negedge clk);
      chk($sformatf("row%0d R1/R6 redirect", i), 32'(redirect), 32'(TBL[i].e_redir));
      chk($sformatf("row%0d R1/R6/R12/R13 vector", i), vector, TBL[i].e_vec);
      chk($sformatf("row%0d R7 ret_pc", i), ret_pc, TBL[i].e_epc);
      chk($sformatf("row%0d R2/R3/R9 nmi", i), 32'(status_nmi), 32'(TBL[i].e_nmi));
      chk($sformatf("row%0d R4/R11/R12 exl", i), 32'(status_exl), 32'(TBL[i].e_exl));
      chk($sformatf("row%0d R8 bd", i), 32'(cause_bd), 32'(TBL[i].e_bd));
      chk($sformatf("row%0d R5 int_en", i), 32'(int_en), 32'(!TBL[i].e_exl));
    end

    // R10: a long NMI request produces a single redirect
    idle_inputs();
    @(negedge clk);
    pc = 32'h700;
    nmi_req = 1'b1;
    pulses = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (redirect) pulses++;
    end
    chk("R10 pulse count", 32'(pulses), 32'd1);
    chk("R10 ret_pc", ret_pc, 32'h700);

    // R4: asynchronous reset in mid-cycle returns to the reset state
    nmi_req = 1'b0;
    @(negedge clk);
    #5 rst_n = 1'b0;
    #1 chk_reset_state("async reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_reset_state("re-release");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule